// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block gathers event pulses from the data path and sequencer of a serial-bus controller into a 16-bit sticky status register. A 5-bit enable mask chooses which of the low status events raise the single level interrupt. A small DMA configuration register sends the receive-ready and transmit-ready events to two DMA request lines instead of the interrupt.

Software uses a simple register port. Reading the status word returns the stored events, with the live bus-busy level placed in bit 12. Reading the vector word returns the 1-based index of the lowest enabled pending event and clears that event in the same access. Turning DMA on for a direction clears that direction's enable bit in the mask, so the same event cannot raise both an interrupt and a DMA request.

Top module: `irqVectorUnit`

## Requirements
- R1: `irqOut` is high exactly when `status[4:0] & mask` is nonzero. It follows a set pulse or a mask write one clock later.
- R2: A write to address 0 loads only `regWrData[4:0]` into the mask. A read of address 0 returns the mask with zeros above it.
- R3: A read of address 1 returns the stored status with the live `busBusy` level in bit 12. A set pulse on bit 12 is not stored.
- R4: A read of address 2 returns 0 when no enabled status bit is set. Otherwise it returns the index of the lowest set bit of `status & mask` plus one, and clears only that status bit at the clock edge of the read.
- R5: The DMA register at address 3 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). All other bits read as zero.
- R6: `rxDmaReq` equals status bit 3 (receive-ready) while receive DMA is enabled. `txDmaReq` equals status bit 4 (transmit-ready) while transmit DMA is enabled. A request line whose enable is off is low.
- R7: A DMA register write with bit 15 set clears mask bit 3. A DMA register write with bit 7 set clears mask bit 4. The other mask bits are unchanged.
- R8: Writes to the status address (1), the vector address (2) and the unmapped addresses (4 to 7) change no register.
- R9: If a set pulse and a vector-read clear hit the same status bit in the same cycle, the bit stays set.
- R10: After reset the mask, status, DMA register, interrupt and both DMA requests are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (vector reads clear at this edge) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid while regRdEn is high, zero otherwise |
| statusSet | input | 16 | Per-bit status set pulses |
| busBusy | input | 1 | Live bus-busy level |
| irqOut | output | 1 | Level interrupt |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The vector read is tested with several enabled events pending at once, and is read until it returns zero. This shows that the lowest bit wins, that one read clears exactly one bit, and that a pending bit outside the mask is never reported. A read made in the same cycle as a set pulse on that same bit shows that the set wins over the clear. The DMA register is written with the receive enable alone, the transmit enable alone and both together. This shows that each request line follows its own status bit and that each write clears only its own mask bit. Writes to the read-only and unmapped addresses are followed by reads of every register, which shows that they change nothing.

// File: rtl/irqStatPkg.sv
`timescale 1ns/1ps
package irqStatPkg;
  // Word addresses of the register port
  localparam int ADDR_MASK   = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_VECTOR = 2;
  localparam int ADDR_DMA    = 3;

  // Status bit positions used by the logic
  localparam int BIT_NACK     = 1;
  localparam int BIT_ACC_RDY  = 2;
  localparam int BIT_RX_RDY   = 3;
  localparam int BIT_TX_RDY   = 4;
  localparam int BIT_SLV_ADDR = 9;
  localparam int BIT_TX_UNDER = 10;
  localparam int BIT_RX_OVER  = 11;
  localparam int BIT_BUSY     = 12;
  localparam int BIT_ONE_BYTE = 15;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_STATUS, SEL_VECTOR, SEL_DMA
  } readSel_t;

  typedef struct packed {
    logic     wrMask;
    logic     wrDma;
    logic     rdVector;
    readSel_t readSel;
  } strobe_t;
endpackage

// File: rtl/irqCtrlDecode.sv
`timescale 1ns/1ps
module irqCtrlDecode
  import irqStatPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  logic isMask, isStatus, isVector, isDma;

  always_comb begin
    isMask   = (regAddr == ADDR_W'(ADDR_MASK));
    isStatus = (regAddr == ADDR_W'(ADDR_STATUS));
    isVector = (regAddr == ADDR_W'(ADDR_VECTOR));
    isDma    = (regAddr == ADDR_W'(ADDR_DMA));

    strb.wrMask   = regWrEn && isMask;
    strb.wrDma    = regWrEn && isDma;
    strb.rdVector = regRdEn && isVector;
    strb.readSel  = SEL_NONE;
    if (regRdEn) begin
      if (isMask)        strb.readSel = SEL_MASK;
      else if (isStatus) strb.readSel = SEL_STATUS;
      else if (isVector) strb.readSel = SEL_VECTOR;
      else if (isDma)    strb.readSel = SEL_DMA;
    end
  end

  // R8: writes to read-only or unmapped words raise no write strobe
  assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !isMask && !isDma) |-> (!strb.wrMask && !strb.wrDma));
endmodule

// File: rtl/irqStatusDatapath.sv
`timescale 1ns/1ps
module irqStatusDatapath
  import irqStatPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 5,
  parameter int BUSY_BIT   = BIT_BUSY,
  parameter int RX_RDY_BIT = BIT_RX_RDY,
  parameter int TX_RDY_BIT = BIT_TX_RDY,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] statusSet,
  input  logic              busBusy,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  localparam int VEC_W = $clog2(MASK_W + 1);
  localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << BUSY_BIT);

  logic [DATA_W-1:0] statusReg, statusNext, clrFull;
  logic [MASK_W-1:0] maskReg, maskNext, pending, clrOneHot;
  logic              rxDmaEn, txDmaEn;
  logic [VEC_W-1:0]  vecIdx;
  logic              unusedWr;

  assign unusedWr = ^regWrData;

  // Lowest enabled pending source
  always_comb begin
    pending   = statusReg[MASK_W-1:0] & maskReg;
    clrOneHot = pending & (~pending + MASK_W'(1));
    vecIdx    = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (pending[i]) vecIdx = VEC_W'(i + 1);
    end
  end

  // Set pulses win over the vector-read clear
  always_comb begin
    clrFull    = strb.rdVector ? DATA_W'(clrOneHot) : '0;
    statusNext = (statusReg & ~clrFull) | (statusSet & STORE_MASK);
  end

  always_comb begin
    maskNext = maskReg;
    if (strb.wrMask) begin
      maskNext = regWrData[MASK_W-1:0];
    end else if (strb.wrDma) begin
      if (regWrData[RX_DMA_BIT]) maskNext[RX_RDY_BIT] = 1'b0;
      if (regWrData[TX_DMA_BIT]) maskNext[TX_RDY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      maskReg   <= '0;
      rxDmaEn   <= 1'b0;
      txDmaEn   <= 1'b0;
    end else begin
      statusReg <= statusNext;
      maskReg   <= maskNext;
      if (strb.wrDma) begin
        rxDmaEn <= regWrData[RX_DMA_BIT];
        txDmaEn <= regWrData[TX_DMA_BIT];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (strb.readSel)
      SEL_MASK:   regRdData = DATA_W'(maskReg);
      SEL_STATUS: regRdData = statusReg | (DATA_W'(busBusy) << BUSY_BIT);
      SEL_VECTOR: regRdData = DATA_W'(vecIdx);
      SEL_DMA: begin
        regRdData[RX_DMA_BIT] = rxDmaEn;
        regRdData[TX_DMA_BIT] = txDmaEn;
      end
      default:    regRdData = '0;
    endcase
  end

  assign irqOut   = |pending;
  assign rxDmaReq = rxDmaEn && statusReg[RX_RDY_BIT];
  assign txDmaReq = txDmaEn && statusReg[TX_RDY_BIT];

  assert_irq_follows_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((|(statusSet[MASK_W-1:0] & maskReg)) && !strb.wrMask && !strb.wrDma) |=> irqOut);

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> (maskReg == $past(regWrData[MASK_W-1:0])));

  assert_busy_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readSel == SEL_STATUS) |-> (regRdData[BUSY_BIT] == busBusy));

  assert_vector_clears_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdVector && (|pending) && (statusSet == '0))
      |=> ($countones(statusReg) == $countones($past(statusReg)) - 1));

  assert_rx_req_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rxDmaEn |-> !rxDmaReq);

  assert_tx_req_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txDmaEn |-> !txDmaReq);

  assert_dma_clears_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDma && regWrData[RX_DMA_BIT]) |=> !maskReg[RX_RDY_BIT]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusSet & STORE_MASK))
      |=> ((statusReg & $past(statusSet & STORE_MASK)) == $past(statusSet & STORE_MASK)));
endmodule

// File: rtl/irqVectorUnit.sv
`timescale 1ns/1ps
module irqVectorUnit
  import irqStatPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MASK_W = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] statusSet,
  input  logic              busBusy,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  strobe_t strb;

  irqCtrlDecode #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irqStatusDatapath #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .statusSet (statusSet),
    .busBusy   (busBusy),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .rxDmaReq  (rxDmaReq),
    .txDmaReq  (txDmaReq)
  );
endmodule

// File: tb/test_irqVectorUnit.sv
`timescale 1ns/1ps
module test_irqVectorUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [15:0] statusSet = '0;
  logic        busBusy = 1'b0;
  logic        irqOut, rxDmaReq, txDmaReq;

  int checks = 0;
  int fails  = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  irqVectorUnit i_irqVectorUnit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .statusSet(statusSet), .busBusy(busBusy), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    statusSet = v;
    @(negedge clk);
    statusSet = '0;
    #1;
  endtask

  task automatic testReset();
    logic [15:0] d;
    check("R10 irq", {15'd0, irqOut}, 16'd0);
    check("R10 rxReq", {15'd0, rxDmaReq}, 16'd0);
    check("R10 txReq", {15'd0, txDmaReq}, 16'd0);
    readReg(3'd0, d); check("R10 mask", d, 16'h0000);
    readReg(3'd1, d); check("R10 status", d, 16'h0000);
    readReg(3'd3, d); check("R10 dma", d, 16'h0000);
  endtask

  task automatic testMaskWidth();
    logic [15:0] d;
    writeReg(3'd0, 16'hFFFF);
    readReg(3'd0, d); check("R2 mask keeps 4:0", d, 16'h001F);
  endtask

  task automatic testIrqLevel();
    writeReg(3'd0, 16'h0004);
    #1 check("R1 no pending", {15'd0, irqOut}, 16'd0);
    pulse(16'h0004);
    check("R1 enabled set", {15'd0, irqOut}, 16'd1);
    pulse(16'h0200);
    check("R1 still high", {15'd0, irqOut}, 16'd1);
    writeReg(3'd0, 16'h0000);
    #1 check("R1 masked off", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testBusyBit();
    logic [15:0] d;
    busBusy = 1'b1;
    readReg(3'd1, d); check("R3 busy inserted", d, 16'h1204);
    pulse(16'h1000);
    busBusy = 1'b0;
    readReg(3'd1, d); check("R3 bit12 not stored", d, 16'h0204);
  endtask

  task automatic testVector();
    logic [15:0] d;
    writeReg(3'd0, 16'h001F);
    pulse(16'h000A);
    check("R1 irq on", {15'd0, irqOut}, 16'd1);
    readReg(3'd2, d); check("R4 vector lowest", d, 16'd2);
    readReg(3'd2, d); check("R4 vector next", d, 16'd3);
    readReg(3'd2, d); check("R4 vector third", d, 16'd4);
    readReg(3'd2, d); check("R4 vector empty", d, 16'd0);
    readReg(3'd1, d); check("R4 only unmasked left", d, 16'h0200);
    check("R4 irq drops", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testDma();
    logic [15:0] d;
    writeReg(3'd3, 16'hFFFF);
    readReg(3'd3, d); check("R5 dma bits", d, 16'h8080);
    readReg(3'd0, d); check("R7 both cleared", d, 16'h0007);
    writeReg(3'd0, 16'h001F);
    writeReg(3'd3, 16'h8000);
    readReg(3'd3, d); check("R5 rx only", d, 16'h8000);
    readReg(3'd0, d); check("R7 rx clears bit3", d, 16'h0017);
    pulse(16'h0018);
    check("R6 rxReq on", {15'd0, rxDmaReq}, 16'd1);
    check("R6 txReq off", {15'd0, txDmaReq}, 16'd0);
    writeReg(3'd3, 16'h0080);
    #1;
    check("R6 rxReq off", {15'd0, rxDmaReq}, 16'd0);
    check("R6 txReq on", {15'd0, txDmaReq}, 16'd1);
    readReg(3'd0, d); check("R7 tx clears bit4", d, 16'h0007);
    writeReg(3'd3, 16'h0000);
    #1;
    check("R6 rx disabled", {15'd0, rxDmaReq}, 16'd0);
    check("R6 tx disabled", {15'd0, txDmaReq}, 16'd0);
  endtask

  task automatic testRejected();
    logic [15:0] d;
    writeReg(3'd1, 16'hFFFF);
    writeReg(3'd2, 16'hFFFF);
    writeReg(3'd5, 16'hFFFF);
    readReg(3'd1, d); check("R8 status kept", d, 16'h0218);
    readReg(3'd0, d); check("R8 mask kept", d, 16'h0007);
    readReg(3'd3, d); check("R8 dma kept", d, 16'h0000);
    check("R8 irq low", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testSetWins();
    logic [15:0] d;
    pulse(16'h0002);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 3'd2; statusSet = 16'h0002;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; statusSet = '0;
    check("R9 vector value", d, 16'd2);
    readReg(3'd1, d); check("R9 set survives", d, 16'h021A);
    readReg(3'd2, d); check("R4 plain clear", d, 16'd2);
    readReg(3'd1, d); check("R4 bit cleared", d, 16'h0218);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testMaskWidth();
    testIrqLevel();
    testBusyBit();
    testVector();
    testDma();
    testRejected();
    testSetWins();
    doneFlag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule